// File: doc/BRIEF.md
# Chunked Print-Line Buffer Serializer

This block sits between a host processor and a thermal print head. A full print line is longer than the on-chip buffer, so the host sends it in pieces. For each piece, the host writes 16-bit words into a 32-word store and then reads one of two trigger addresses. The block then shifts the stored bits out to the head on a serial data line with its own serial clock. One trigger sends all 512 stored bits. The other sends only the first 192 bits, which serves the short last piece of a 1728-bit line (three long pieces plus one short piece).

Bits leave the block with word 0 first, and within each word the most significant bit first. The serial clock is derived from the system clock. Each bit lasts `2*HALF` system cycles: the clock is low for the first `HALF` cycles and high for the next `HALF` cycles. Data changes only at the start of a bit, so it is steady while the clock is high. A busy flag covers the whole transfer. While busy is set, writes and further triggers are refused, and a refused write raises a sticky overrun flag.

Top module: `psr_chunk_serializer`

## Requirements
- R1: While reset is held and straight after it, `busy`, `overrun`, `sclk` and `sdata` are all 0.
- R2: A write taken while idle stores `wr_data` at word `wr_addr`. The word is held until it is overwritten.
- R3: A pulse on `rd_full_trig` while idle sends 512 bits. Bit k is word k/16, bit position 15-(k mod 16), so word 0 goes first and each word goes MSB first.
- R4: A pulse on `rd_short_trig` while idle sends 192 bits, which are words 0 to 11 in the same order as R3.
- R5: If both triggers are high in the same idle cycle, the full 512-bit transfer is started.
- R6: Each bit lasts 2*HALF system cycles. `sclk` is low for the first HALF cycles and high for the last HALF cycles. Consecutive rising edges of `sclk` are therefore 2*HALF cycles apart, and `sdata` does not change while `sclk` stays high.
- R7: `busy` is 1 from the cycle after the accepting clock edge until the last bit's high phase ends. It stays high for exactly bits*2*HALF cycles.
- R8: A trigger that arrives while `busy` is 1 has no effect. The running transfer keeps its length and its duration.
- R9: A write that arrives while `busy` is 1 leaves the stored word unchanged and sets `overrun` to 1.
- R10: `overrun` stays at 1 until the next accepted trigger, which clears it in the same cycle that `busy` rises.
- R11: While `busy` is 0, `sclk` and `sdata` are both held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host buffer write strobe |
| wr_addr | input | 5 | Word address of the write |
| wr_data | input | 16 | Word to store |
| rd_full_trig | input | 1 | Read strobe of the trigger that starts a 512-bit transfer |
| rd_short_trig | input | 1 | Read strobe of the trigger that starts a 192-bit transfer |
| busy | output | 1 | Transfer in progress |
| overrun | output | 1 | Sticky flag for a write refused while busy |
| sclk | output | 1 | Serial clock to the print head |
| sdata | output | 1 | Serial data to the print head |

## Verification
The assertions assume that both trigger strobes and the write strobe are synchronous to `clk` and last one cycle for each host access. They also assume that the host does not write the buffer in the same cycle that it triggers a transfer. The bench drives every strobe for exactly one cycle, changing inputs on the falling edge of `clk`. It issues refused writes and triggers only at points where it has seen `busy` high, and it never combines a write with a trigger in the same cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_FULL  = 2'd1,
    SEL_SHORT = 2'd2
  } chunk_sel_e;

  // Word that holds serial bit number idx
  function automatic int word_of(input int idx, input int w);
    return idx / w;
  endfunction

  // Bit position inside that word; MSB leaves first
  function automatic int lane_of(input int idx, input int w);
    return w - 1 - (idx % w);
  endfunction

  // Number of bits in a chunk of the chosen kind
  function automatic int chunk_bits(input logic is_short, input int words,
                                    input int short_words, input int w);
    return (is_short ? short_words : words) * w;
  endfunction

  // Full trigger has priority over short trigger
  function automatic chunk_sel_e pick(input logic f, input logic s);
    if (f) return SEL_FULL;
    if (s) return SEL_SHORT;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/psr_line_buf.sv
module psr_line_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (we && waddr == AW'(g))
        mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/psr_bit_clock.sv
module psr_bit_clock #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_hi,
  output logic bit_end
);

  localparam int PERIOD = 2 * HALF;
  localparam int PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      ph_q <= '0;
    else if (ph_q == PH_W'(PERIOD - 1))
      ph_q <= '0;
    else
      ph_q <= ph_q + 1'b1;
  end

  assign sclk_hi = run && (ph_q >= PH_W'(HALF));
  assign bit_end = run && (ph_q == PH_W'(PERIOD - 1));

endmodule

// File: rtl/psr_shift_ctrl.sv
module psr_shift_ctrl
  import psr_pkg::*;
#(
  parameter int W           = 16,
  parameter int DEPTH       = 32,
  parameter int SHORT_WORDS = 12,
  localparam int CW         = $clog2(DEPTH * W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_full,
  input  logic          trig_short,
  input  logic          wr_en,
  input  logic          bit_end,
  output logic          busy,
  output logic          overrun,
  output logic [CW-1:0] bit_cnt,
  output logic          accept,
  output logic          last_done,
  output logic          wr_ok
);

  chunk_sel_e    sel;
  logic          busy_q;
  logic          ovr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_q;

  assign sel       = pick(trig_full, trig_short);
  assign accept    = !busy_q && (sel != SEL_NONE);
  assign last_done = busy_q && bit_end && (cnt_q == last_q);
  assign wr_ok     = wr_en && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      last_q <= CW'(chunk_bits(sel == SEL_SHORT, DEPTH, SHORT_WORDS, W) - 1);
    end else if (last_done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && bit_end) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ovr_q <= 1'b0;
    else if (accept)
      ovr_q <= 1'b0;
    else if (wr_en && busy_q)
      ovr_q <= 1'b1;
  end

  assign busy    = busy_q;
  assign overrun = ovr_q;
  assign bit_cnt = cnt_q;

endmodule

// File: rtl/psr_chunk_serializer.sv
module psr_chunk_serializer
  import psr_pkg::*;
#(
  parameter int W           = 16,
  parameter int DEPTH       = 32,
  parameter int SHORT_WORDS = 12,
  parameter int HALF        = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_full_trig,
  input  logic                     rd_short_trig,
  output logic                     busy,
  output logic                     overrun,
  output logic                     sclk,
  output logic                     sdata
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(W);
  localparam int CW = $clog2(DEPTH * W);

  logic          wr_ok;
  logic          accept;
  logic          last_done;
  logic          bit_end;
  logic          sclk_hi;
  logic [CW-1:0] bit_cnt;
  logic [AW-1:0] raddr;
  logic [LW-1:0] lane;
  logic [W-1:0]  rd_word;

  psr_shift_ctrl #(
    .W(W), .DEPTH(DEPTH), .SHORT_WORDS(SHORT_WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_full (rd_full_trig),
    .trig_short(rd_short_trig),
    .wr_en     (wr_en),
    .bit_end   (bit_end),
    .busy      (busy),
    .overrun   (overrun),
    .bit_cnt   (bit_cnt),
    .accept    (accept),
    .last_done (last_done),
    .wr_ok     (wr_ok)
  );

  psr_bit_clock #(.HALF(HALF)) u_bclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .sclk_hi(sclk_hi),
    .bit_end(bit_end)
  );

  psr_line_buf #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_ok),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(raddr),
    .rdata(rd_word)
  );

  assign raddr = AW'(word_of(int'(bit_cnt), W));
  assign lane  = LW'(lane_of(int'(bit_cnt), W));
  assign sclk  = sclk_hi;
  assign sdata = busy && rd_word[lane];

endmodule

// File: rtl/psr_chunk_serializer_chk.sv
module psr_chunk_serializer_chk #(
  parameter int W           = 16,
  parameter int DEPTH       = 32,
  parameter int SHORT_WORDS = 12
) (
  input logic clk,
  input logic rst_n,
  input logic rd_full_trig,
  input logic rd_short_trig,
  input logic wr_en,
  input logic busy,
  input logic overrun,
  input logic sclk,
  input logic sdata,
  input logic accept,
  input logic last_done
);

  logic sclk_d;
  int   rise_cnt;
  int   exp_len;
  logic rise_now;

  assign rise_now = sclk && !sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= 0;
      exp_len  <= 0;
    end else begin
      sclk_d <= sclk;
      if (accept) begin
        rise_cnt <= 0;
        exp_len  <= rd_full_trig ? DEPTH * W : SHORT_WORDS * W;
      end else if (rise_now) begin
        rise_cnt <= rise_cnt + 1;
      end
    end
  end

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (rd_full_trig || rd_short_trig)) |=> busy);

  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> !busy);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_done) |=> busy);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !sdata));

  // R6
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && sclk_d) |-> $stable(sdata));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> overrun);

  // R10
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !overrun);

  // R3 R4 R5
  chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |-> ((rise_cnt + int'(rise_now)) == exp_len));

endmodule

bind psr_chunk_serializer psr_chunk_serializer_chk #(
  .W(W), .DEPTH(DEPTH), .SHORT_WORDS(SHORT_WORDS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_full_trig (rd_full_trig),
  .rd_short_trig(rd_short_trig),
  .wr_en        (wr_en),
  .busy         (busy),
  .overrun      (overrun),
  .sclk         (sclk),
  .sdata        (sdata),
  .accept       (accept),
  .last_done    (last_done)
);

// File: tb/tb_psr_chunk_serializer.sv
module tb_psr_chunk_serializer;

  localparam int W = 16, DEPTH = 32, SHORT = 12, HALF = 2;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic rd_full_trig = 1'b0, rd_short_trig = 1'b0;
  logic busy, overrun, sclk, sdata;

  always #10 clk = ~clk;

  psr_chunk_serializer #(.W(W), .DEPTH(DEPTH), .SHORT_WORDS(SHORT), .HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_full_trig(rd_full_trig), .rd_short_trig(rd_short_trig),
    .busy(busy), .overrun(overrun), .sclk(sclk), .sdata(sdata));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] mdl [DEPTH];
  logic cap [DEPTH*W];
  int nrise, busy_cyc, hold_viol, idle_viol, per_viol, since_rise;
  logic prev_sclk = 1'b0, prev_sdata = 1'b0;

  // Observer: samples on the falling edge of clk
  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (busy) busy_cyc++;
      if (!busy && (sclk || sdata)) idle_viol++;
      if (sclk && prev_sclk && sdata != prev_sdata) hold_viol++;
      if (sclk && !prev_sclk) begin
        if (nrise > 0 && since_rise != 2*HALF) per_viol++;
        if (nrise < DEPTH*W) cap[nrise] = sdata;
        nrise++;
        since_rise = 0;
      end
      prev_sclk  = sclk;
      prev_sdata = sdata;
    end
  end

  function automatic logic exp_bit(input int k);
    return mdl[k / W][W - 1 - (k % W)];
  endfunction

  function automatic int exp_len(input bit full);
    return full ? DEPTH * W : SHORT * W;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    if (!busy) mdl[a] = d;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start(input bit f, input bit s, input string req);
    nrise = 0; busy_cyc = 0; hold_viol = 0; idle_viol = 0; per_viol = 0;
    since_rise = 0;
    @(negedge clk);
    rd_full_trig = f; rd_short_trig = s;
    @(negedge clk);
    rd_full_trig = 1'b0; rd_short_trig = 1'b0;
    chk(busy == 1'b1, "R7", {req, " busy after trigger"}, int'(busy), 1);
    chk(overrun == 1'b0, "R10", {req, " overrun cleared on accept"}, int'(overrun), 0);
  endtask

  task automatic finish(input bit full, input string req);
    int guard = 0;
    int bad = 0;
    int first = -1;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(nrise == exp_len(full), req, "bit count", nrise, exp_len(full));
    chk(busy_cyc == exp_len(full) * 2 * HALF, "R7", "busy length", busy_cyc,
        exp_len(full) * 2 * HALF);
    for (int k = 0; k < exp_len(full) && k < nrise; k++)
      if (cap[k] !== exp_bit(k)) begin
        bad++;
        if (first < 0) first = k;
      end
    chk(bad == 0, req, "mismatching bits (first index in next field)", bad, 0);
    if (bad != 0) $display("     first bad bit %0d", first);
    chk(per_viol == 0 && hold_viol == 0, "R6", "clock period/hold violations",
        per_viol + hold_viol, 0);
    chk(idle_viol == 0, "R11", "idle activity", idle_viol, 0);
  endtask

  task automatic fill_random();
    for (int a = 0; a < DEPTH; a++) wr(a, W'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int a = 0; a < DEPTH; a++) mdl[a] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk({busy, overrun, sclk, sdata} == 4'b0, "R1", "outputs in reset",
        int'({busy, overrun, sclk, sdata}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, overrun, sclk, sdata} == 4'b0, "R1", "outputs after reset",
        int'({busy, overrun, sclk, sdata}), 0);

    // R2 R3: random contents, full chunk
    fill_random();
    start(1, 0, "R3"); finish(1, "R3");
    // R2 R4: short chunk of the same buffer, then new contents
    start(0, 1, "R4"); finish(0, "R4");
    fill_random();
    start(0, 1, "R2"); finish(0, "R2");

    // R5: both triggers together
    start(1, 1, "R5"); finish(1, "R5");

    // Directed patterns: all ones, all zeros, alternating
    for (int a = 0; a < DEPTH; a++) wr(a, '1);
    start(1, 0, "R3"); finish(1, "R3");
    for (int a = 0; a < DEPTH; a++) wr(a, '0);
    start(0, 1, "R4"); finish(0, "R4");
    for (int a = 0; a < DEPTH; a++) wr(a, (a % 2) ? W'(16'h5A5A) : W'(16'h8001));
    start(1, 0, "R3"); finish(1, "R3");

    // R8 R9: trigger and writes while busy
    chk(overrun == 1'b0, "R9", "overrun idle before", int'(overrun), 0);
    start(0, 1, "R8");
    repeat (37) @(negedge clk);
    rd_full_trig = 1'b1;
    @(negedge clk);
    rd_full_trig = 1'b0;
    wr(0, ~mdl[0]);
    wr(5, ~mdl[5]);
    finish(0, "R8");
    chk(overrun == 1'b1, "R9", "overrun set by busy write", int'(overrun), 1);
    repeat (20) @(negedge clk);
    chk(overrun == 1'b1, "R10", "overrun sticky", int'(overrun), 1);
    // Accept clears overrun (checked in start); data shows writes were dropped
    start(0, 1, "R9"); finish(0, "R9");

    // Random mix
    for (int it = 0; it < 8; it++) begin
      bit f, s;
      for (int n = 0; n < 10; n++) wr(int'($urandom_range(DEPTH - 1)), W'($urandom));
      f = 1'($urandom); s = 1'($urandom);
      if (!f && !s) s = 1'b1;
      start(f, s, f ? "R3" : "R4");
      finish(f, f ? "R3" : "R4");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule